// File: doc/BRIEF.md
# Single-Error-Correcting Hamming Codec for 16-Bit Words

This block protects a 16-bit memory word with five even-parity check bits. Its encode path takes a data word and produces a 21-bit protected word. Its decode path takes a 21-bit word that may have been corrupted while it was stored. The decoder recomputes every check, forms a syndrome, repairs a single flipped bit and returns the data together with error indications. The two paths are independent and may be used in the same cycle.

Bits in the protected word are numbered 1 to 21 from the most significant end. Bus bit 20 is position 1 and bus bit 0 is position 21. Check bits sit at the power-of-two positions. Data fills the other positions in ascending position order, with the most significant data bit first. Each path has a valid strobe, and its results appear registered one clock later. There is no handshake.

Top module: `hsec_codec`

## Requirements
- R1: The encoder places data bit 15 at position 3, then the remaining data bits in descending order at positions 5, 6, 7, 9–15 and 17–21. Position p maps to bus bit 21-p. Check bits occupy positions 1, 2, 4, 8 and 16.
- R2: The check at position 2^k makes even the count of ones over every position whose binary index has bit k set. That set includes the check position itself.
- R3: Data 1111000010101110 encodes to 001011100000101101110, written from position 1 to position 21. With position 5 of that word inverted, the decoder reports syndrome 5 and returns the original data.
- R4: Syndrome bit k is set when the check of weight 2^k fails. The syndrome is therefore the sum of the weights of the failing checks, and it is zero for an intact word.
- R5: When the syndrome is between 1 and 21, the decoder inverts that position before it extracts the data. Any single inverted data position therefore yields the original data.
- R6: When the single inverted position is a check position, the data output equals the original data and the error flag is set.
- R7: A syndrome from 22 to 31 sets the uncorrectable flag. No bit is inverted, and the data is extracted as received.
- R8: The error flag is 1 exactly when the syndrome is nonzero.
- R9: Each valid output rises exactly one clock after its valid input. Data, codeword and syndrome outputs keep their values on cycles without a valid input.
- R10: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encode request strobe |
| enc_data_i | input | 16 | Data word to protect |
| dec_valid_i | input | 1 | Decode request strobe |
| dec_cw_i | input | 21 | Received protected word, position 1 at bit 20 |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_cw_o | output | 21 | Encoded protected word |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 16 | Corrected data |
| dec_syndrome_o | output | 5 | Syndrome, the position of the indicated error |
| dec_err_o | output | 1 | Syndrome nonzero |
| dec_uncorr_o | output | 1 | Syndrome points beyond position 21 |

## Verification
The bench inverts each of the 21 positions in turn on several data words. A design that reversed the bit numbering, or that mixed up the order of the data positions, would repair the wrong bit and return corrupted data. Flips at check positions show up any design that lets a check-bit repair alter the data. Chosen double flips produce syndromes 22 and 31, which a design without a range guard would handle by inverting some unrelated bit or by leaving the flag low. Idle gaps and a reset in the middle of the run catch outputs that drift when no strobe is present, and a latency that is off by one.

// File: rtl/hsec_pkg.sv
package hsec_pkg;
  localparam int MAX_CW = 64;

  function automatic int chk_bits(input int dw);
    int r;
    r = 0;
    for (int i = 1; i < 7; i++)
      if (r == 0 && (1 << i) >= dw + i + 1) r = i;
    return r;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // position (1-based, from MSB) that holds data bit i
  function automatic int data_pos(input int dw, input int i);
    int want, seen, pos;
    want = dw - 1 - i;
    seen = 0;
    pos  = 0;
    for (int p = 1; p < MAX_CW; p++)
      if (pos == 0 && !is_pow2(p)) begin
        if (seen == want) pos = p;
        seen++;
      end
    return pos;
  endfunction

  // bus mask of positions covered by the check of weight 2^k
  function automatic logic [MAX_CW-1:0] cover_mask(input int cw_w, input int k);
    logic [MAX_CW-1:0] m;
    m = '0;
    for (int p = 1; p <= cw_w; p++)
      if (((p >> k) & 1) == 1) m[cw_w-p] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = hsec_pkg::chk_bits(DATA_W),
  parameter int CW_W   = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  logic [CW_W-1:0] spread;
  logic [CHK_W-1:0] par;

  for (genvar i = 0; i < DATA_W; i++) begin : g_place
    assign spread[CW_W - hsec_pkg::data_pos(DATA_W, i)] = data_i[i];
  end

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [hsec_pkg::MAX_CW-1:0] MASK = hsec_pkg::cover_mask(CW_W, k);
    assign spread[CW_W - (1 << k)] = 1'b0;
    assign par[k] = ^(spread & MASK[CW_W-1:0]);
  end

  always_comb begin
    cw_o = spread;
    for (int k = 0; k < CHK_W; k++)
      cw_o[CW_W - (1 << k)] = par[k];
  end
endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome #(
  parameter int CHK_W = 5,
  parameter int CW_W  = 21
) (
  input  logic [CW_W-1:0]  cw_i,
  output logic [CHK_W-1:0] syn_o
);
  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    localparam logic [hsec_pkg::MAX_CW-1:0] MASK = hsec_pkg::cover_mask(CW_W, k);
    assign syn_o[k] = ^(cw_i & MASK[CW_W-1:0]);
  end
endmodule

// File: rtl/hsec_corrector.sv
module hsec_corrector #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 5,
  parameter int CW_W   = 21
) (
  input  logic [CW_W-1:0]   cw_i,
  input  logic [CHK_W-1:0]  syn_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o,
  output logic              uncorr_o
);
  logic [CW_W-1:0] flip;
  logic [CW_W-1:0] fixed;

  for (genvar p = 1; p <= CW_W; p++) begin : g_flip
    assign flip[CW_W-p] = (syn_i == CHK_W'(p));
  end

  assign fixed    = cw_i ^ flip;
  assign err_o    = |syn_i;
  assign uncorr_o = syn_i > CHK_W'(CW_W);

  for (genvar i = 0; i < DATA_W; i++) begin : g_extract
    assign data_o[i] = fixed[CW_W - hsec_pkg::data_pos(DATA_W, i)];
  end

  always_comb begin
    // R5
    single_flip_chk: assert ($onehot0(flip));
    // R7
    no_flip_when_uncorr_chk: assert (!uncorr_o || $countones(flip) == 0);
  end
endmodule

// File: rtl/hsec_codec.sv
module hsec_codec #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = hsec_pkg::chk_bits(DATA_W),
  parameter int CW_W   = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  input  logic              dec_valid_i,
  input  logic [CW_W-1:0]   dec_cw_i,
  output logic              enc_valid_o,
  output logic [CW_W-1:0]   enc_cw_o,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [CHK_W-1:0]  dec_syndrome_o,
  output logic              dec_err_o,
  output logic              dec_uncorr_o
);
  logic [CW_W-1:0]   enc_cw_w;
  logic [CHK_W-1:0]  syn_w;
  logic [DATA_W-1:0] data_w;
  logic              err_w;
  logic              uncorr_w;

  hsec_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_enc (
    .data_i(enc_data_i), .cw_o(enc_cw_w)
  );

  hsec_syndrome #(.CHK_W(CHK_W), .CW_W(CW_W)) u_syn (
    .cw_i(dec_cw_i), .syn_o(syn_w)
  );

  hsec_corrector #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_cor (
    .cw_i(dec_cw_i), .syn_i(syn_w), .data_o(data_w),
    .err_o(err_w), .uncorr_o(uncorr_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_valid_o    <= 1'b0;
      enc_cw_o       <= '0;
      dec_valid_o    <= 1'b0;
      dec_data_o     <= '0;
      dec_syndrome_o <= '0;
      dec_err_o      <= 1'b0;
      dec_uncorr_o   <= 1'b0;
    end else begin
      enc_valid_o <= enc_valid_i;
      dec_valid_o <= dec_valid_i;
      if (enc_valid_i) enc_cw_o <= enc_cw_w;
      if (dec_valid_i) begin
        dec_data_o     <= data_w;
        dec_syndrome_o <= syn_w;
        dec_err_o      <= err_w;
        dec_uncorr_o   <= uncorr_w;
      end
    end
  end

  // R9
  enc_latency_chk: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_valid_o);
  // R9
  dec_latency_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> dec_valid_o);
  // R9
  dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> $stable(dec_data_o) && $stable(dec_syndrome_o));
  // R7
  uncorr_err_chk: assert property (@(posedge clk) disable iff (rst)
    dec_uncorr_o |-> dec_err_o);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!enc_valid_o && !dec_valid_o && enc_cw_o == '0 && !dec_err_o));
endmodule

// File: tb/hsec_codec_bench.sv
module hsec_codec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_valid_i = 1'b0;
  logic [15:0] enc_data_i = '0;
  logic        dec_valid_i = 1'b0;
  logic [20:0] dec_cw_i = '0;
  logic        enc_valid_o;
  logic [20:0] enc_cw_o;
  logic        dec_valid_o;
  logic [15:0] dec_data_o;
  logic [4:0]  dec_syndrome_o;
  logic        dec_err_o;
  logic        dec_uncorr_o;

  hsec_codec u_hsec_codec (
    .clk(clk), .rst(rst),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .dec_valid_i(dec_valid_i), .dec_cw_i(dec_cw_i),
    .enc_valid_o(enc_valid_o), .enc_cw_o(enc_cw_o),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_syndrome_o(dec_syndrome_o), .dec_err_o(dec_err_o),
    .dec_uncorr_o(dec_uncorr_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [20:0] cw;
    logic [15:0] data;
    logic [4:0]  syn;
    logic        err;
    logic        unc;
    logic        chkpos;
    int          due;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] last_data = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pw2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // R1 R2: place data MSB first, then checks as parity of covered positions
  function automatic logic [20:0] ref_enc(input logic [15:0] d);
    logic [20:0] w;
    int n;
    w = '0;
    n = 15;
    for (int p = 1; p <= 21; p++)
      if (!pw2(p)) begin w[21-p] = d[n]; n--; end
    for (int k = 0; k < 5; k++) begin
      logic b;
      b = 1'b0;
      for (int p = 1; p <= 21; p++)
        if (((p >> k) & 1) == 1) b = b ^ w[21-p];
      w[21-(1<<k)] = b;
    end
    return w;
  endfunction

  function automatic logic [4:0] ref_syn(input logic [20:0] w);
    logic [4:0] s;
    s = '0;
    for (int p = 1; p <= 21; p++)
      if (w[21-p]) s = s ^ 5'(p);
    return s;
  endfunction

  function automatic logic [15:0] ref_extract(input logic [20:0] w);
    logic [15:0] d;
    int n;
    d = '0;
    n = 15;
    for (int p = 1; p <= 21; p++)
      if (!pw2(p)) begin d[n] = w[21-p]; n--; end
    return d;
  endfunction

  task automatic drive(input logic [15:0] d, input logic [20:0] flipmask);
    item_t it;
    logic [20:0] rx, fx;
    @(negedge clk);
    it.cw = ref_enc(d);
    rx = it.cw ^ flipmask;
    it.syn = ref_syn(rx);
    it.err = (it.syn != 0);
    it.unc = (it.syn > 5'd21);
    fx = rx;
    if (it.err && !it.unc) fx[21 - int'(it.syn)] = ~fx[21 - int'(it.syn)];
    it.data = ref_extract(fx);
    it.chkpos = $countones(flipmask) == 1 && pw2(int'(it.syn));
    it.due = cyc + 1;
    enc_valid_i = 1'b1; enc_data_i = d;
    dec_valid_i = 1'b1; dec_cw_i = rx;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [20:0] pos(input int p);
    return 21'(1) << (21 - p);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (dec_valid_o || enc_valid_o)) begin
      if (q.size() == 0) begin
        check(1'b0, "R9 unexpected valid", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(cyc == it.due && enc_valid_o && dec_valid_o, "R9 latency", cyc, it.due);
        check(enc_cw_o == it.cw, "R1/R2 codeword", enc_cw_o, it.cw);
        check(dec_syndrome_o == it.syn, "R4 syndrome", dec_syndrome_o, it.syn);
        check(dec_err_o == it.err, "R8 error flag", dec_err_o, it.err);
        check(dec_uncorr_o == it.unc, "R7 uncorrectable flag", dec_uncorr_o, it.unc);
        if (it.chkpos)
          check(dec_data_o == it.data, "R6 check-position repair data", dec_data_o, it.data);
        else
          check(dec_data_o == it.data, "R5 corrected data", dec_data_o, it.data);
        last_data = dec_data_o;
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 3000);
    finish_run();
  end

  initial begin
    logic [15:0] vals [4];
    repeat (2) @(negedge clk);
    // R10 reset state
    check(!enc_valid_o && !dec_valid_o && enc_cw_o == 0 && dec_data_o == 0 &&
          dec_syndrome_o == 0 && !dec_err_o && !dec_uncorr_o, "R10 reset outputs", 1, 0);
    rst = 1'b0;

    // R3 worked example, literal expected values
    drive(16'b1111000010101110, '0);
    drive(16'b1111000010101110, pos(5));
    idle(1);
    @(negedge clk);
    check(dec_syndrome_o == 5'd5, "R3 syndrome of example", dec_syndrome_o, 5);
    check(dec_data_o == 16'b1111000010101110, "R3 restored data", dec_data_o, 16'hF0AE);
    drive(16'b1111000010101110, '0);
    idle(1);
    check(enc_cw_o == 21'b001011100000101101110, "R3 example codeword", enc_cw_o, 21'b001011100000101101110);

    // R5 R6 every single position on several words
    vals[0] = 16'h0000; vals[1] = 16'hFFFF; vals[2] = 16'hA5C3; vals[3] = 16'h0001;
    for (int v = 0; v < 4; v++)
      for (int p = 1; p <= 21; p++) drive(vals[v], pos(p));

    // R7 out-of-range syndromes, and an aliasing double flip
    drive(16'h1234, pos(21) | pos(3));
    drive(16'h1234, pos(16) | pos(15));
    drive(16'hBEEF, pos(1) | pos(2));

    // R9 hold across idle cycles
    idle(4);
    check(!dec_valid_o && !enc_valid_o, "R9 valid low when idle", dec_valid_o, 0);
    check(dec_data_o == last_data, "R9 data held when idle", dec_data_o, last_data);

    // random traffic
    for (int i = 0; i < 300; i++) begin
      int p;
      p = int'($urandom_range(0, 21));
      drive(16'($urandom), p == 0 ? 21'(0) : pos(p));
    end
    idle(3);

    // R10 reset mid run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!enc_valid_o && !dec_valid_o && enc_cw_o == 0 && dec_data_o == 0 &&
          dec_syndrome_o == 0 && !dec_err_o && !dec_uncorr_o, "R10 mid-run reset", 1, 0);
    rst = 1'b0;
    check(q.size() == 0, "R9 all results delivered", q.size(), 0);
    finish_run();
  end
endmodule